// File: doc/BRIEF.md
# USB Host Frame Countdown Timer

This block keeps the frame timing of a USB host controller. A 14-bit down counter holds the number of bit times left in the current frame. It steps down once on every bit-time strobe. When it has run out, it reloads from a programmable frame-interval value at the next strobe and marks the start of a new frame with a one-cycle pulse. A 16-bit frame number advances with every such pulse.

Each reload also copies an interval toggle bit into a status flag. Software flips that bit whenever it writes a new interval. When the status flag matches the toggle bit, software knows the new interval is in use. Count and flag are presented together in a read-only 32-bit status word.

A small state machine handles the operational state and has three states: IDLE, LAUNCH and RUN.
- IDLE: the host is not operational. The count, the flag and the frame number hold their values, and no frame pulses are issued.
- IDLE→LAUNCH: taken in the first cycle in which the operational input is seen high. In that cycle the interval and its toggle bit are captured again.
- LAUNCH→RUN: taken on the first bit-time strobe after entry. That strobe loads the captured interval and fires the first frame pulse.
- RUN: the count steps down on each strobe, waits at zero without a strobe, and reloads from the live interval input at the strobe after reaching zero.
- LAUNCH→IDLE and RUN→IDLE: taken as soon as the operational input goes low.

Top module: `usb_frame_timer`

## Requirements
- R1: `status_word` bit 31 is the toggle flag, bits 13..0 are the remaining count, and bits 30..14 always read as zero. The word has no write path.
- R2: In RUN, a bit-time strobe with the count non-zero lowers the count by exactly one at that clock edge.
- R3: In RUN, a strobe seen while the count is zero reloads the count from the live `interval_val` input at that edge. The reload never happens in the cycle in which the count reached zero. An interval of zero reloads zero, which gives a frame at every strobe.
- R4: While the count is zero and no strobe is present, the count stays zero.
- R5: Every reload copies a toggle value into bit 31 of the status word. A reload from the live input copies the live `interval_tgl`. The first reload after entry copies the toggle captured at entry.
- R6: While `oper_state` is low, the count, the toggle flag and the frame number keep their values, strobes have no effect, and `sof_pulse` stays low.
- R7: `sof_pulse` is high for exactly one clock cycle: the cycle right after the edge at which a reload took place, which is the same cycle in which the reloaded count first appears.
- R8: In the first cycle in which `oper_state` is seen high, `interval_val` and `interval_tgl` are captured. A strobe in that same cycle is ignored. The first strobe in a later cycle loads the captured values, not the live ones, and causes a frame pulse.
- R9: `frame_number` increases by one with each `sof_pulse` and wraps modulo 2^FNUM_W.
- R10: After reset, the status word, the frame number and `sof_pulse` are all zero and the machine is in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle strobe at each bit-time boundary |
| interval_val | input | CNT_W (14) | Programmable frame interval in bit times |
| interval_tgl | input | 1 | Toggle bit that accompanies the interval |
| oper_state | input | 1 | High while the host is in the operational state |
| sof_pulse | output | 1 | One-cycle start-of-frame pulse |
| status_word | output | 32 | Read-only status: toggle flag in bit 31, count in bits 13..0 |
| frame_number | output | FNUM_W (16) | Frame number, advanced at each frame start |

## Verification
The bench keeps the counter at its full 14-bit width and builds the frame number with FNUM_W = 4. With that width, a wrap of the frame number is reached after sixteen frames. The bench runs one complete frame at the largest interval, 16383, and sweeps every interval from 0 to 20. A cycle-level expected model, computed in the bench from the requirements, is compared against every output in every cycle. The model covers dense and sparse strobes, toggle changes, interval changes made between entry and the first strobe, and exits from and re-entries into the operational state in the middle of a frame.

// File: rtl/usb_ft_pkg.sv
package usb_ft_pkg;
    typedef enum logic [1:0] {
        FT_IDLE   = 2'd0,
        FT_LAUNCH = 2'd1,
        FT_RUN    = 2'd2
    } ft_state_e;
endpackage

// File: rtl/usb_ft_ctrl.sv
module usb_ft_ctrl
    import usb_ft_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      oper_i,
    input  logic      tick_i,
    input  logic      zero_i,
    output logic      capture_o,
    output logic      load_shadow_o,
    output logic      load_live_o,
    output logic      dec_o,
    output ft_state_e state_o
);
    ft_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FT_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FT_IDLE:   if (oper_i) state_d = FT_LAUNCH;
            FT_LAUNCH: if (!oper_i) state_d = FT_IDLE;
                       else if (tick_i) state_d = FT_RUN;
            FT_RUN:    if (!oper_i) state_d = FT_IDLE;
            default:   state_d = FT_IDLE;
        endcase
    end

    // command outputs
    always_comb begin
        capture_o     = 1'b0;
        load_shadow_o = 1'b0;
        load_live_o   = 1'b0;
        dec_o         = 1'b0;
        unique case (state_q)
            FT_IDLE:   capture_o = oper_i;
            FT_LAUNCH: load_shadow_o = oper_i & tick_i;
            FT_RUN: begin
                load_live_o = oper_i & tick_i & zero_i;
                dec_o       = oper_i & tick_i & ~zero_i;
            end
            default: ;
        endcase
    end

    assign state_o = state_q;

    // R8: the first load after entry only follows the capture cycle
    a_r8_launch_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
        load_shadow_o |-> $past(state_q) != FT_RUN);
endmodule

// File: rtl/usb_ft_counter.sv
module usb_ft_counter #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture_i,
    input  logic             load_shadow_i,
    input  logic             load_live_i,
    input  logic             dec_i,
    input  logic [CNT_W-1:0] ival_i,
    input  logic             itgl_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             tgl_o,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_q, sh_q;
    logic             tgl_q, sht_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sh_q  <= '0;
            tgl_q <= 1'b0;
            sht_q <= 1'b0;
        end else begin
            if (capture_i) begin
                sh_q  <= ival_i;
                sht_q <= itgl_i;
            end
            if (load_shadow_i) begin
                cnt_q <= sh_q;
                tgl_q <= sht_q;
            end else if (load_live_i) begin
                cnt_q <= ival_i;
                tgl_q <= itgl_i;
            end else if (dec_i) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign cnt_o  = cnt_q;
    assign tgl_o  = tgl_q;
    assign zero_o = (cnt_q == '0);

    // R2: a step lowers the count by exactly one
    a_r2_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        dec_i |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/usb_ft_fnum.sv
module usb_ft_fnum #(
    parameter int FNUM_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc_i,
    output logic [FNUM_W-1:0] fnum_o
);
    logic [FNUM_W-1:0] fnum_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     fnum_q <= '0;
        else if (inc_i) fnum_q <= fnum_q + 1'b1;
    end

    assign fnum_o = fnum_q;
endmodule

// File: rtl/usb_frame_timer.sv
module usb_frame_timer
    import usb_ft_pkg::*;
#(
    parameter int CNT_W  = 14,
    parameter int FNUM_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic [CNT_W-1:0]  interval_val,
    input  logic              interval_tgl,
    input  logic              oper_state,
    output logic              sof_pulse,
    output logic [31:0]       status_word,
    output logic [FNUM_W-1:0] frame_number
);
    localparam int PAD_W = 31 - CNT_W;

    logic             capture, load_sh, load_lv, dec, zero, tgl, sof_q;
    logic [CNT_W-1:0] cnt;
    ft_state_e        state;

    usb_ft_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .oper_i(oper_state), .tick_i(bit_tick),
        .zero_i(zero), .capture_o(capture), .load_shadow_o(load_sh),
        .load_live_o(load_lv), .dec_o(dec), .state_o(state)
    );

    usb_ft_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .capture_i(capture), .load_shadow_i(load_sh),
        .load_live_i(load_lv), .dec_i(dec), .ival_i(interval_val),
        .itgl_i(interval_tgl), .cnt_o(cnt), .tgl_o(tgl), .zero_o(zero)
    );

    usb_ft_fnum #(.FNUM_W(FNUM_W)) u_fnum (
        .clk(clk), .rst_n(rst_n), .inc_i(load_sh | load_lv), .fnum_o(frame_number)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sof_q <= 1'b0;
        else        sof_q <= load_sh | load_lv;
    end

    assign sof_pulse   = sof_q;
    assign status_word = {tgl, {PAD_W{1'b0}}, cnt};

    // R6: outside the operational state nothing moves
    a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !oper_state |=> $stable(status_word) && $stable(frame_number) && !sof_pulse);
    // R7: a frame pulse always follows an operational strobe
    a_r7_sof_from_tick: assert property (@(posedge clk) disable iff (!rst_n)
        sof_pulse |-> $past(bit_tick) && $past(oper_state));
    // R9: frame number advances with each pulse
    a_r9_fnum_inc: assert property (@(posedge clk) disable iff (!rst_n)
        sof_pulse |-> frame_number == $past(frame_number) + 1'b1);
    // R4: zero without strobe stays zero
    a_r4_zero_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && !bit_tick) |=> cnt == '0);
    // R8: the first pulse after entry comes out of LAUNCH
    a_r8_first_from_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (sof_pulse && $past(state) != FT_RUN) |-> $past(state) == FT_LAUNCH);
endmodule

// File: tb/usb_frame_timer_test.sv
`timescale 1ns/1ps
module usb_frame_timer_test;
    localparam int CW = 14;
    localparam int FW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bit_tick = 1'b0;
    logic [CW-1:0] interval_val = '0;
    logic          interval_tgl = 1'b0;
    logic          oper_state = 1'b0;
    logic          sof_pulse;
    logic [31:0]   status_word;
    logic [FW-1:0] frame_number;

    int n_chk = 0;
    int n_bad = 0;
    string cur_req = "R10";

    // expected model state
    int            m_st = 0;
    logic [CW-1:0] m_cnt = '0, m_sh = '0;
    logic          m_tgl = 1'b0, m_sht = 1'b0, m_sof = 1'b0;
    logic [FW-1:0] m_fn = '0;

    always #10 clk = ~clk;

    usb_frame_timer #(.CNT_W(CW), .FNUM_W(FW)) uut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .interval_val(interval_val),
        .interval_tgl(interval_tgl), .oper_state(oper_state), .sof_pulse(sof_pulse),
        .status_word(status_word), .frame_number(frame_number)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk(cur_req, "count", {18'd0, status_word[CW-1:0]}, {18'd0, m_cnt});
        chk("R5", "toggle", {31'd0, status_word[31]}, {31'd0, m_tgl});
        chk("R1", "pad bits", {15'd0, status_word[30:14]}, 32'd0);
        chk("R7", "sof", {31'd0, sof_pulse}, {31'd0, m_sof});
        chk("R9", "frame", {28'd0, frame_number}, {28'd0, m_fn});
    endtask

    // one clock: drive at negedge, update model, compare at the next negedge
    task automatic cyc(input logic tk, input logic op);
        bit_tick   = tk;
        oper_state = op;
        m_sof = 1'b0;
        case (m_st)
            0: if (op) begin m_sh = interval_val; m_sht = interval_tgl; m_st = 1; end
            1: if (!op) m_st = 0;
               else if (tk) begin
                   m_cnt = m_sh; m_tgl = m_sht; m_sof = 1'b1; m_fn = m_fn + 1'b1; m_st = 2;
               end
            default: if (!op) m_st = 0;
               else if (tk) begin
                   if (m_cnt == 0) begin
                       m_cnt = interval_val; m_tgl = interval_tgl; m_sof = 1'b1; m_fn = m_fn + 1'b1;
                   end else m_cnt = m_cnt - 1'b1;
               end
        endcase
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state
        cur_req = "R10";
        compare_all();

        // R6: strobes while not operational have no effect
        cur_req = "R6";
        interval_val = 14'd6;
        repeat (5) cyc(1'b1, 1'b0);

        // R8: entry captures interval, later changes do not affect first load
        cur_req = "R8";
        interval_val = 14'd5; interval_tgl = 1'b1;
        cyc(1'b1, 1'b1);
        interval_val = 14'd9; interval_tgl = 1'b0;
        repeat (2) cyc(1'b0, 1'b1);
        cyc(1'b1, 1'b1);

        // R2: count down to zero
        cur_req = "R2";
        repeat (5) cyc(1'b1, 1'b1);
        // R3: reload from live value after zero
        cur_req = "R3";
        cyc(1'b1, 1'b1);

        // R4: sparse strobes, zero waits for the next strobe
        cur_req = "R4";
        interval_val = 14'd4;
        for (int i = 0; i < 60; i++) cyc(i % 3 == 0, 1'b1);

        // R5: toggle follows each reload
        cur_req = "R5";
        for (int f = 0; f < 6; f++) begin
            interval_tgl = f[0];
            interval_val = CW'(f);
            repeat (8) cyc(1'b1, 1'b1);
        end

        // R3: zero interval gives a frame at every strobe
        cur_req = "R3";
        interval_val = 14'd0;
        repeat (6) cyc(1'b1, 1'b1);

        // R6: leave operational mid-frame, then re-enter (R8)
        cur_req = "R6";
        interval_val = 14'd7;
        repeat (4) cyc(1'b1, 1'b1);
        repeat (4) cyc(1'b1, 1'b0);
        repeat (2) cyc(1'b0, 1'b0);
        cur_req = "R8";
        interval_val = 14'd3; interval_tgl = 1'b1;
        cyc(1'b1, 1'b1);
        interval_val = 14'd11; interval_tgl = 1'b0;
        repeat (6) cyc(1'b1, 1'b1);

        // R9: many short frames wrap the 4-bit frame number
        cur_req = "R9";
        interval_val = 14'd2;
        repeat (80) cyc(1'b1, 1'b1);

        // R2: one full frame at the largest interval
        cur_req = "R2";
        interval_val = 14'd16383; interval_tgl = 1'b1;
        repeat (16400) cyc(1'b1, 1'b1);

        // R3: sweep of small intervals
        cur_req = "R3";
        for (int v = 0; v <= 20; v++) begin
            interval_val = CW'(v);
            interval_tgl = v[0];
            repeat (v + 3) cyc(1'b1, 1'b1);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule